// File: doc/BRIEF.md
# Oversampled Asynchronous Character Receiver

This block turns an asynchronous serial line into characters. A free-running enable marks sixteen sample points per bit period by default; the line passes through a short synchronizer and is then timed against that enable. A falling edge is not trusted at once. The line is looked at again half a bit later. Only if it is still low does the block start assembling data bits, so short spikes cost nothing. The character length (5 to 8 bits) and an optional even or odd parity bit are chosen through static configuration inputs.

A finished character sits in an output register with its parity, framing and overrun flags until the consumer pulses a read acknowledge. A stop bit sampled low with non-zero data is reported as a framing error on that character. After such an error the search for the next start bit is held off for half a bit. An all-zero character whose stop bit is also low is taken as a line break. No character is delivered for it. Instead one pulse marks the start of the break and another marks the return of the line to idle.

Top module: `serial_char_rx`

## Requirements
- R1: After the synchronized line is seen low on a tick, it is sampled again OVS/2 ticks later; if it is high then, the event is dropped and no character and no break event result.
- R2: Data bits are sampled every OVS ticks after the validated start sample, least significant bit first; cfg_len 0,1,2,3 selects 5,6,7,8 data bits, and rx_data bits above the selected length read zero.
- R3: With cfg_par_en high, one parity bit follows the data; cfg_par_odd low means the data plus parity must hold an even number of ones, high means an odd number; rx_perr is set with the character when this fails and is always zero with parity off.
- R4: A stop bit sampled low with at least one data bit set delivers the character with rx_ferr set; a stop bit sampled high delivers it with rx_ferr clear.
- R5: After a framing error the receiver ignores the line for OVS/2 ticks after the stop sample before it searches for a start bit again, so a low line that continues into the next start bit is not taken early.
- R6: A character whose data bits are all zero and whose stop bit is sampled low raises brk_start for one clock and delivers no character; no character is delivered while the break lasts.
- R7: During a break the first tick that sees the synchronized line high raises brk_end for one clock and the receiver returns to start-bit search.
- R8: rx_valid rises one clock after the stop-sample edge and stays high until rd_ack; a character that completes while rx_valid is high and rd_ack is low replaces the held one and sets rx_ovr, which otherwise is loaded as zero.
- R9: During reset rx_valid, rx_ovr, rx_perr, rx_ferr, brk_start and brk_end are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Oversample enable, OVS pulses per bit period |
| rx_in | input | 1 | Asynchronous serial line, idle high |
| cfg_len | input | LEN_W | Character length select, 0 = 5 bits up to 3 = 8 bits |
| cfg_par_en | input | 1 | Parity bit present and checked |
| cfg_par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_ack | input | 1 | Consumer has taken the held character |
| rx_valid | output | 1 | A character is held |
| rx_data | output | 8 | Held character, zero above its length |
| rx_perr | output | 1 | Parity error on the held character |
| rx_ferr | output | 1 | Framing error on the held character |
| rx_ovr | output | 1 | Held character overwrote an unread one |
| brk_start | output | 1 | One-clock pulse when a break is recognized |
| brk_end | output | 1 | One-clock pulse when a break ends |

## Verification
The hardest state to reach is the framing error whose low line runs straight on into the next start bit. Only there does the half-bit holdoff decide where the next character's bit centers fall. The bench builds it by sending a frame with a low stop bit and starting the following frame with no idle gap. It then checks that the second character arrives intact. Breaks, spikes shorter than half a bit, and back-to-back unread characters are driven as well. A behavioural model in the bench, built on tick counts since each detected edge, is compared with every output on every clock.

// File: rtl/rx_pkg.sv
package rx_pkg;
   localparam int unsigned RXP_DATA_W = 8;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_DATA,
      ST_PAR,
      ST_STOP,
      ST_BRK,
      ST_HOLD
   } rx_state_e;

   typedef struct packed {
      logic [RXP_DATA_W-1:0] data;
      logic                  perr;
      logic                  ferr;
   } rx_char_t;
endpackage

// File: rtl/rx_in_sync.sv
module rx_in_sync #(
   parameter int unsigned STAGES    = 2,
   parameter bit          RESET_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain;

   generate
      genvar gi;
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= d_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= RESET_VAL;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign q_out = chain[STAGES-1];
endmodule

// File: rtl/rx_bit_engine.sv
module rx_bit_engine
   import rx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned MIN_LEN     = 5,
   parameter int unsigned LEN_W       = 2,
   parameter bit          PAR_SUPPORT = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ln,
   input  logic [LEN_W-1:0] cfg_len,
   input  logic             cfg_par_en,
   input  logic             cfg_par_odd,
   output logic             done_o,
   output rx_char_t         chr_o,
   output logic             brk_start_o,
   output logic             brk_end_o
);
   localparam int unsigned CNT_W = $clog2(OVS);
   localparam int unsigned HALF  = OVS / 2;
   localparam int unsigned IDX_W = $clog2(RXP_DATA_W);

   rx_state_e             state;
   logic [CNT_W-1:0]      cnt;
   logic [IDX_W-1:0]      bidx;
   logic [IDX_W-1:0]      last_idx;
   logic [RXP_DATA_W-1:0] shreg;
   logic                  pbit;
   logic                  use_par;
   logic                  par_bad;
   logic                  full_pt;
   logic                  half_pt;

   assign last_idx = IDX_W'(cfg_len) + IDX_W'(MIN_LEN - 1);
   assign full_pt  = tick && (cnt == CNT_W'(OVS - 1));
   assign half_pt  = tick && (cnt == CNT_W'(HALF - 1));

   generate
      if (PAR_SUPPORT) begin : g_par
         assign use_par = cfg_par_en;
         assign par_bad = cfg_par_en & (^shreg ^ pbit ^ cfg_par_odd);
      end else begin : g_nopar
         assign use_par = 1'b0;
         assign par_bad = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         cnt         <= '0;
         bidx        <= '0;
         shreg       <= '0;
         pbit        <= 1'b0;
         chr_o       <= '0;
         done_o      <= 1'b0;
         brk_start_o <= 1'b0;
         brk_end_o   <= 1'b0;
      end else begin
         done_o      <= 1'b0;
         brk_start_o <= 1'b0;
         brk_end_o   <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (tick && !ln) begin
                  state <= ST_START;
                  cnt   <= '0;
               end
            end
            ST_START: begin
               if (half_pt) begin
                  cnt <= '0;
                  if (!ln) begin
                     state <= ST_DATA;
                     bidx  <= '0;
                     shreg <= '0;
                  end else begin
                     state <= ST_IDLE;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_DATA: begin
               if (full_pt) begin
                  cnt         <= '0;
                  shreg[bidx] <= ln;
                  if (bidx == last_idx) state <= use_par ? ST_PAR : ST_STOP;
                  else                  bidx  <= bidx + 1'b1;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_PAR: begin
               if (full_pt) begin
                  cnt   <= '0;
                  pbit  <= ln;
                  state <= ST_STOP;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_STOP: begin
               if (full_pt) begin
                  cnt        <= '0;
                  chr_o.data <= shreg;
                  chr_o.perr <= par_bad;
                  if (ln) begin
                     done_o     <= 1'b1;
                     chr_o.ferr <= 1'b0;
                     state      <= ST_IDLE;
                  end else if (shreg == '0) begin
                     brk_start_o <= 1'b1;
                     state       <= ST_BRK;
                  end else begin
                     done_o     <= 1'b1;
                     chr_o.ferr <= 1'b1;
                     state      <= ST_HOLD;
                  end
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_BRK: begin
               if (tick && ln) begin
                  brk_end_o <= 1'b1;
                  state     <= ST_IDLE;
               end
            end
            ST_HOLD: begin
               if (half_pt) begin
                  cnt   <= '0;
                  state <= ST_IDLE;
               end else if (tick) begin
                  cnt <= cnt + 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   AST_SPIKE_DROPPED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_START && half_pt && ln) |=> (state == ST_IDLE && !done_o)); // R1
   AST_FERR_HOLDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && chr_o.ferr) |-> (state == ST_HOLD)); // R5
   AST_BRK_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BRK) |-> !done_o); // R6
   AST_BRK_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      brk_start_o |=> !brk_start_o); // R6
   AST_BRK_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      brk_end_o |-> (state == ST_IDLE && $past(state) == ST_BRK)); // R7
endmodule

// File: rtl/rx_char_hold.sv
module rx_char_hold
   import rx_pkg::*;
(
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  done_i,
   input  rx_char_t              chr_i,
   input  logic                  rd_ack,
   output logic                  valid_q,
   output logic [RXP_DATA_W-1:0] data_q,
   output logic                  perr_q,
   output logic                  ferr_q,
   output logic                  ovr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         data_q  <= '0;
         perr_q  <= 1'b0;
         ferr_q  <= 1'b0;
         ovr_q   <= 1'b0;
      end else if (done_i) begin
         valid_q <= 1'b1;
         data_q  <= chr_i.data;
         perr_q  <= chr_i.perr;
         ferr_q  <= chr_i.ferr;
         ovr_q   <= valid_q & ~rd_ack;
      end else if (rd_ack) begin
         valid_q <= 1'b0;
      end
   end

   AST_OVR_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
      (done_i && valid_q && !rd_ack) |=> (ovr_q && valid_q)); // R8
   AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_ack && !done_i) |=> !valid_q); // R8
   AST_DONE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
      done_i |=> valid_q); // R8
endmodule

// File: rtl/serial_char_rx.sv
module serial_char_rx
   import rx_pkg::*;
#(
   parameter int unsigned OVS         = 16,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned MIN_LEN     = 5,
   parameter int unsigned MAX_LEN     = 8,
   parameter bit          PAR_SUPPORT = 1'b1,
   localparam int unsigned LEN_W      = $clog2(MAX_LEN - MIN_LEN + 1)
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  tick_en,
   input  logic                  rx_in,
   input  logic [LEN_W-1:0]      cfg_len,
   input  logic                  cfg_par_en,
   input  logic                  cfg_par_odd,
   input  logic                  rd_ack,
   output logic                  rx_valid,
   output logic [RXP_DATA_W-1:0] rx_data,
   output logic                  rx_perr,
   output logic                  rx_ferr,
   output logic                  rx_ovr,
   output logic                  brk_start,
   output logic                  brk_end
);
   generate
      if (OVS < 4 || (OVS % 2) != 0) begin : g_bad_ovs
         $error("OVS must be even and at least 4");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (MIN_LEN < 1 || MAX_LEN > RXP_DATA_W || MIN_LEN >= MAX_LEN) begin : g_bad_len
         $error("character length range does not fit the data register");
      end
   endgenerate

   logic     line_s;
   logic     done;
   rx_char_t chr;

   rx_in_sync #(
      .STAGES    (SYNC_STAGES),
      .RESET_VAL (1'b1)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (rx_in),
      .q_out (line_s)
   );

   rx_bit_engine #(
      .OVS         (OVS),
      .MIN_LEN     (MIN_LEN),
      .LEN_W       (LEN_W),
      .PAR_SUPPORT (PAR_SUPPORT)
   ) u_eng (
      .clk         (clk),
      .rst_n       (rst_n),
      .tick        (tick_en),
      .ln          (line_s),
      .cfg_len     (cfg_len),
      .cfg_par_en  (cfg_par_en),
      .cfg_par_odd (cfg_par_odd),
      .done_o      (done),
      .chr_o       (chr),
      .brk_start_o (brk_start),
      .brk_end_o   (brk_end)
   );

   rx_char_hold u_hold (
      .clk     (clk),
      .rst_n   (rst_n),
      .done_i  (done),
      .chr_i   (chr),
      .rd_ack  (rd_ack),
      .valid_q (rx_valid),
      .data_q  (rx_data),
      .perr_q  (rx_perr),
      .ferr_q  (rx_ferr),
      .ovr_q   (rx_ovr)
   );

   AST_BRK_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(brk_start && brk_end)); // R7
   AST_NO_CHAR_ON_BRK: assert property (@(posedge clk) disable iff (!rst_n)
      (brk_start && !rx_valid) |=> !rx_valid); // R6
endmodule

// File: tb/sim_serial_char_rx.sv
module sim_serial_char_rx;
   localparam int OVS  = 16;
   localparam int STG  = 2;
   localparam int TDIV = 3;
   localparam int BITC = OVS * TDIV;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_en = 1'b0;
   logic       rx_in = 1'b1;
   logic [1:0] cfg_len = 2'd3;
   logic       cfg_par_en = 1'b0;
   logic       cfg_par_odd = 1'b0;
   logic       rd_ack = 1'b0;
   logic       rx_valid, rx_perr, rx_ferr, rx_ovr, brk_start, brk_end;
   logic [7:0] rx_data;

   int n_chk = 0;
   int n_bad = 0;
   bit cmp_on = 1'b0;
   int tcnt = 0;
   int bs_cnt = 0;
   int be_cnt = 0;

   always #5 clk = ~clk;

   serial_char_rx #(.OVS(OVS), .SYNC_STAGES(STG)) u0 (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .rx_in(rx_in),
      .cfg_len(cfg_len), .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd),
      .rd_ack(rd_ack), .rx_valid(rx_valid), .rx_data(rx_data),
      .rx_perr(rx_perr), .rx_ferr(rx_ferr), .rx_ovr(rx_ovr),
      .brk_start(brk_start), .brk_end(brk_end)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   // behavioural reference: ticks counted from each detected edge
   bit   sq[$];
   int   ph, tk, k, acc;
   bit   m_done, m_cpe, m_cfe, m_bs, m_be;
   int   m_cd;
   bit   m_valid, m_pe, m_fe, m_ovr;
   int   m_data;

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sq = {};
         for (int i = 0; i < STG; i++) sq.push_back(1'b1);
         ph = 0; tk = 0; k = 0; acc = 0;
         m_done = 0; m_cpe = 0; m_cfe = 0; m_bs = 0; m_be = 0; m_cd = 0;
         m_valid = 0; m_pe = 0; m_fe = 0; m_ovr = 0; m_data = 0;
      end else begin
         int  len, nb, dat, pb;
         bit  ln;
         if (m_done) begin
            m_ovr = m_valid && !rd_ack;
            m_valid = 1; m_data = m_cd; m_pe = m_cpe; m_fe = m_cfe;
         end else if (rd_ack) begin
            m_valid = 0;
         end
         m_done = 0; m_bs = 0; m_be = 0;
         ln  = sq[0];
         len = int'(cfg_len) + 5;
         nb  = len + (cfg_par_en ? 1 : 0);
         if (tick_en) begin
            case (ph)
               0: if (!ln) begin ph = 1; tk = 0; end
               1: begin
                  tk++;
                  if (tk == OVS / 2) begin
                     if (!ln) begin ph = 2; tk = 0; k = 0; acc = 0; end
                     else ph = 0;
                  end
               end
               2: begin
                  tk++;
                  if (tk == OVS) begin
                     tk = 0;
                     if (ln) acc = acc | (1 << k);
                     k++;
                     if (k == nb) ph = 3;
                  end
               end
               3: begin
                  tk++;
                  if (tk == OVS) begin
                     tk  = 0;
                     dat = acc & ((1 << len) - 1);
                     pb  = (acc >> len) & 1;
                     m_cd  = dat;
                     m_cpe = cfg_par_en && ((($countones(dat) + pb) % 2) != int'(cfg_par_odd));
                     if (ln) begin m_done = 1; m_cfe = 0; ph = 0; end
                     else if (dat == 0) begin m_bs = 1; ph = 4; end
                     else begin m_done = 1; m_cfe = 1; ph = 5; end
                  end
               end
               4: if (ln) begin m_be = 1; ph = 0; end
               5: begin
                  tk++;
                  if (tk == OVS / 2) begin ph = 0; tk = 0; end
               end
               default: ph = 0;
            endcase
         end
         void'(sq.pop_front());
         sq.push_back(rx_in);
      end
   end

   always @(negedge clk) begin
      tcnt    <= (tcnt == TDIV - 1) ? 0 : tcnt + 1;
      tick_en <= (tcnt == TDIV - 1);
      if (cmp_on) begin
         chk(rx_valid == m_valid, "R8 rx_valid", int'(rx_valid), int'(m_valid));
         chk(int'(rx_data) == m_data, "R2 rx_data", int'(rx_data), m_data);
         chk(rx_perr == m_pe, "R3 rx_perr", int'(rx_perr), int'(m_pe));
         chk(rx_ferr == m_fe, "R4 rx_ferr", int'(rx_ferr), int'(m_fe));
         chk(rx_ovr == m_ovr, "R8 rx_ovr", int'(rx_ovr), int'(m_ovr));
         chk(brk_start == m_bs, "R6 brk_start", int'(brk_start), int'(m_bs));
         chk(brk_end == m_be, "R7 brk_end", int'(brk_end), int'(m_be));
         if (brk_start) bs_cnt++;
         if (brk_end) be_cnt++;
      end
   end

   task automatic hold_line(input bit v, input int nbits);
      rx_in = v;
      repeat (nbits * BITC) @(negedge clk);
   endtask

   task automatic send_frame(input int nb, input logic [7:0] d, input bit pe,
                             input bit podd, input bit flip, input bit stopv);
      bit par = podd;
      hold_line(1'b0, 1);
      for (int i = 0; i < nb; i++) begin
         hold_line(d[i], 1);
         par = par ^ d[i];
      end
      if (pe) hold_line(par ^ flip, 1);
      hold_line(stopv, 1);
   endtask

   task automatic ack();
      rd_ack = 1'b1;
      @(negedge clk);
      rd_ack = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      #(200000 * 10);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      // R9: reset state
      chk(!rx_valid && !rx_ovr && !rx_perr && !rx_ferr, "R9 flags in reset",
          {rx_valid, rx_ovr, rx_perr, rx_ferr}, 0);
      chk(!brk_start && !brk_end, "R9 break pulses in reset", {brk_start, brk_end}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      cmp_on = 1'b1;
      hold_line(1'b1, 2);

      // R2 8 bits, no parity
      cfg_len = 2'd3; cfg_par_en = 0;
      send_frame(8, 8'hA5, 0, 0, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_valid && rx_data == 8'hA5, "R2 8-bit char", int'(rx_data), 'hA5);
      chk(!rx_ferr, "R4 good stop", int'(rx_ferr), 0);
      ack();
      chk(!rx_valid, "R8 ack clears valid", int'(rx_valid), 0);

      // R3 5 bits even parity, good then bad
      cfg_len = 2'd0; cfg_par_en = 1; cfg_par_odd = 0;
      send_frame(5, 8'h13, 1, 0, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_data == 8'h13 && !rx_perr, "R3 even parity good", {rx_perr, rx_data}, 'h13);
      ack();
      send_frame(5, 8'h13, 1, 0, 1, 1);
      hold_line(1'b1, 1);
      chk(rx_perr, "R3 even parity bad", int'(rx_perr), 1);
      ack();

      // R3 7 bits odd parity
      cfg_len = 2'd2; cfg_par_odd = 1;
      send_frame(7, 8'h5A, 1, 1, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_data == 8'h5A && !rx_perr, "R3 odd parity good", {rx_perr, rx_data}, 'h5A);
      ack();
      send_frame(7, 8'h5A, 1, 1, 1, 1);
      hold_line(1'b1, 1);
      chk(rx_perr, "R3 odd parity bad", int'(rx_perr), 1);
      ack();

      // R2 6 bits, upper bits zero
      cfg_len = 2'd1; cfg_par_en = 0;
      send_frame(6, 8'hED, 0, 0, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_data == 8'h2D, "R2 6-bit masked", int'(rx_data), 'h2D);
      ack();

      // R1 spike shorter than half a bit
      cfg_len = 2'd3;
      rx_in = 1'b0;
      repeat (4 * TDIV) @(negedge clk);
      hold_line(1'b1, 4);
      chk(!rx_valid, "R1 spike rejected", int'(rx_valid), 0);

      // R4 framing error
      send_frame(8, 8'h3C, 0, 0, 0, 0);
      hold_line(1'b1, 2);
      chk(rx_valid && rx_data == 8'h3C && rx_ferr, "R4 framing error",
          {rx_ferr, rx_data}, 'h13C);
      ack();

      // R5 bad stop running straight into the next start bit
      send_frame(8, 8'h81, 0, 0, 0, 0);
      send_frame(8, 8'h66, 0, 0, 0, 1);
      hold_line(1'b1, 2);
      chk(rx_data == 8'h66 && !rx_ferr, "R5 holdoff keeps next char aligned",
          {rx_ferr, rx_data}, 'h66);
      ack();

      // R6 / R7 break
      hold_line(1'b0, 14);
      chk(bs_cnt == 1 && !rx_valid, "R6 break start, no char", bs_cnt, 1);
      hold_line(1'b1, 2);
      chk(be_cnt == 1, "R7 break end", be_cnt, 1);
      chk(!rx_valid, "R6 break delivers nothing", int'(rx_valid), 0);

      // R8 overrun
      send_frame(8, 8'h11, 0, 0, 0, 1);
      send_frame(8, 8'h22, 0, 0, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_data == 8'h22 && rx_ovr, "R8 overrun", {rx_ovr, rx_data}, 'h122);
      ack();
      send_frame(8, 8'h33, 0, 0, 0, 1);
      hold_line(1'b1, 1);
      chk(rx_data == 8'h33 && !rx_ovr, "R8 no overrun after ack", {rx_ovr, rx_data}, 'h33);
      ack();

      cmp_on = 1'b0;
      $display("  %0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule